// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block stands in for one Ethernet PHY as seen through a MAC's management-frame register. Software writes a 32-bit frame word. The word holds an operation bit, a PHY address, a register number and 16 data bits. The block carries out the register read or write at once, and a read folds the register value back into the low half of the frame word. One cycle after every frame write, a single-cycle done pulse stands in for the management-complete event.

The PHY register state is a small set: basic control, basic status, advertisement, interrupt source and interrupt mask. Each writable register applies its own write mask. A restart of auto-negotiation completes at once. A `link_up` input tracks the cable state and drives the status link bits and the interrupt-source bits. The serial wire protocol is not modelled, and neither are the management clock and real negotiation.

Top module: `mdio_phy_regs`

## Requirements
- R1: After reset, control reads 0x3000, status reads 0x7809, advertisement reads 0x01E1, and interrupt source and mask read 0. The frame word reads 0 and `mgmt_done` is low. The link is taken as down at reset.
- R2: Frame bit 29 set means read and clear means write. Bits 27:23 are the PHY address and bits 22:18 the register number. A write leaves the whole word in the frame register. A read stores bits 31:16 as written and bits 15:0 as the register value, visible from the cycle after the write.
- R3: A write to register 0 stores data AND 0x7980. If data bit 9 (0x0200, restart negotiation) is set, status bit 5 (0x0020) is set in the same update.
- R4: A write to register 4 stores (data AND 0x2D7F) OR 0x0080.
- R5: A write to register 30 keeps data bits 7:0, and register 30 reads those bits with the upper byte zero.
- R6: When `link_up` is high and was low at the previous clock, status bits 0x0024 are set and interrupt-source bits 7 and 6 (0x00C0) are set.
- R7: When `link_up` is low and was high at the previous clock, status bits 0x0024 are cleared and interrupt-source bit 4 (0x0010) is set.
- R8: A read of register 29 returns the pending interrupt-source bits and clears them. Bits raised by a link change in the same cycle stay pending.
- R9: Registers 5, 6 and every unlisted register number read 0. Writes to registers 1, 5, 6, 29 and every unlisted number change nothing.
- R10: A frame whose PHY address differs from `PHY_ADDR` (default 0) reads 0 and changes no PHY register.
- R11: `mgmt_done` is high for exactly the one cycle after each frame write, for reads, writes, ignored and foreign-address frames alike, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_we | input | 1 | Write strobe for the management-frame register |
| frame_wdata | input | 32 | Frame word written |
| frame_rdata | output | 32 | Current frame register contents |
| link_up | input | 1 | Cable link state |
| mgmt_done | output | 1 | Management operation complete pulse |

## Verification
The PHY registers show at the ports only when a read frame returns them. A bad mask, a lost link bit or a stale interrupt bit therefore appears in the low half of `frame_rdata` one cycle after the first read of that register, and not before. The bench compares the frame word and the done pulse against a behavioural model on every clock. It issues reads straight after each write and each link change, so a fault surfaces within two cycles of its cause.

// File: rtl/mdio_phy_regs.sv
module mdio_phy_regs #(
  parameter logic [4:0] PHY_ADDR = 5'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_we,
  input  logic [31:0] frame_wdata,
  output logic [31:0] frame_rdata,
  input  logic        link_up,
  output logic        mgmt_done
);
  localparam logic [4:0] RG_CTL  = 5'd0;
  localparam logic [4:0] RG_STS  = 5'd1;
  localparam logic [4:0] RG_ADV  = 5'd4;
  localparam logic [4:0] RG_ISR  = 5'd29;
  localparam logic [4:0] RG_MASK = 5'd30;
  localparam logic [15:0] LINK_BITS = 16'h0024;

  logic [31:0] frame_q;
  logic [15:0] ctl_q, sts_q, adv_q, sts_n, rd_val;
  logic [7:0]  isr_q, imask_q, isr_n;
  logic        link_q, done_q;

  wire       op_rd   = frame_wdata[29];
  wire [4:0] phy_sel = frame_wdata[27:23];
  wire [4:0] reg_sel = frame_wdata[22:18];
  wire [15:0] wd     = frame_wdata[15:0];
  wire hit    = frame_we && (phy_sel == PHY_ADDR);
  wire rd_hit = hit && op_rd;
  wire wr_hit = hit && !op_rd;
  wire link_rise = link_up && !link_q;
  wire link_fall = !link_up && link_q;

  assign frame_rdata = frame_q;
  assign mgmt_done   = done_q;

  always_comb begin
    rd_val = 16'h0;
    if (hit) begin
      case (reg_sel)
        RG_CTL:  rd_val = ctl_q;
        RG_STS:  rd_val = sts_q;
        RG_ADV:  rd_val = adv_q;
        RG_ISR:  rd_val = {8'h0, isr_q};
        RG_MASK: rd_val = {8'h0, imask_q};
        default: rd_val = 16'h0;
      endcase
    end
  end

  always_comb begin
    sts_n = sts_q;
    if (wr_hit && reg_sel == RG_CTL && wd[9]) sts_n = sts_n | 16'h0020;
    if (link_rise) sts_n = sts_n | LINK_BITS;
    if (link_fall) sts_n = sts_n & ~LINK_BITS;
    isr_n = isr_q;
    if (rd_hit && reg_sel == RG_ISR) isr_n = 8'h0;
    if (link_rise) isr_n = isr_n | 8'hC0;
    if (link_fall) isr_n = isr_n | 8'h10;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= 32'h0;
      ctl_q   <= 16'h3000;
      sts_q   <= 16'h7809;
      adv_q   <= 16'h01E1;
      isr_q   <= 8'h0;
      imask_q <= 8'h0;
      link_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= frame_we;
      link_q <= link_up;
      sts_q  <= sts_n;
      isr_q  <= isr_n;
      if (frame_we) frame_q <= op_rd ? {frame_wdata[31:16], rd_val} : frame_wdata;
      if (wr_hit) begin
        case (reg_sel)
          RG_CTL:  ctl_q   <= wd & 16'h7980;
          RG_ADV:  adv_q   <= (wd & 16'h2D7F) | 16'h0080;
          RG_MASK: imask_q <= wd[7:0];
          default: ;
        endcase
      end
    end
  end

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) frame_we |=> mgmt_done); // R11
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !frame_we |=> !mgmt_done); // R11
  AST_LINK_UP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && !link_q) |=> (sts_q[5] && sts_q[2] && isr_q[7] && isr_q[6])); // R6
  AST_LINK_DOWN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && link_q) |=> (!sts_q[5] && !sts_q[2] && isr_q[4])); // R7
  AST_ISR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && reg_sel == RG_ISR && link_up == link_q) |=> (isr_q == 8'h0)); // R8
  AST_FOREIGN_PHY_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_we && phy_sel != PHY_ADDR) |=> ($stable(ctl_q) && $stable(adv_q) && $stable(imask_q))); // R10
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && reg_sel == RG_CTL) |=> $stable(ctl_q)); // R9
endmodule

// File: tb/tb_mdio_phy_regs.sv
module tb_mdio_phy_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_we = 1'b0;
  logic [31:0] frame_wdata = 32'h0;
  logic link_up = 1'b0;
  logic [31:0] frame_rdata;
  logic mgmt_done;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  int m_frame, m_ctl, m_sts, m_adv, m_isr, m_mask, m_val;
  bit m_link, m_done;

  mdio_phy_regs dut (
    .clk(clk), .rst_n(rst_n), .frame_we(frame_we), .frame_wdata(frame_wdata),
    .frame_rdata(frame_rdata), .link_up(link_up), .mgmt_done(mgmt_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", req, what, got, exp);
    end
  endtask

  task automatic model_step();
    int fr, ph, rg, d, ns, ni;
    bit rise, fall;
    if (!rst_n) begin
      m_frame = 0; m_ctl = 'h3000; m_sts = 'h7809; m_adv = 'h01E1;
      m_isr = 0; m_mask = 0; m_link = 0; m_done = 0;
      return;
    end
    fr = frame_wdata; ph = (fr >> 23) & 'h1f; rg = (fr >> 18) & 'h1f; d = fr & 'hffff;
    rise = link_up && !m_link; fall = !link_up && m_link;
    ns = m_sts; ni = m_isr;
    if (frame_we) begin
      if (ph != 0) m_val = 0;
      else if (rg == 0) m_val = m_ctl;
      else if (rg == 1) m_val = m_sts;
      else if (rg == 4) m_val = m_adv;
      else if (rg == 29) m_val = m_isr;
      else if (rg == 30) m_val = m_mask;
      else m_val = 0;
      if (fr[29]) begin
        m_frame = (fr & 'hffff0000) | m_val;
        if (ph == 0 && rg == 29) ni = 0;
      end else begin
        m_frame = fr;
        if (ph == 0) begin
          if (rg == 0) begin
            m_ctl = d & 'h7980;
            if (d & 'h0200) ns = ns | 'h0020;
          end else if (rg == 4) m_adv = (d & 'h2D7F) | 'h0080;
          else if (rg == 30) m_mask = d & 'hff;
        end
      end
    end
    if (rise) begin ns = ns | 'h0024; ni = ni | 'hC0; end
    if (fall) begin ns = ns & ~'h0024; ni = ni | 'h10; end
    m_sts = ns; m_isr = ni;
    m_link = link_up; m_done = frame_we;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(cur_req, frame_rdata, m_frame, "frame_rdata vs model");
    check(cur_req, int'(mgmt_done), int'(m_done), "mgmt_done vs model");
  endtask

  task automatic mgmt(input bit rd, input int phy, input int rg, input int data);
    frame_we = 1'b1;
    frame_wdata = {2'b01, rd, 1'b0, phy[4:0], rg[4:0], 2'b10, data[15:0]};
    cyc();
    frame_we = 1'b0;
  endtask

  task automatic rd_expect(input string req, input int phy, input int rg, input int exp);
    cur_req = req;
    mgmt(1'b1, phy, rg, 'h5A5A);
    check(req, frame_rdata[15:0], exp, $sformatf("read reg %0d", rg));
    check(req, frame_rdata[31:16], {2'b01, 1'b1, 1'b0, phy[4:0], rg[4:0], 2'b10}, "frame upper half");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    rst_n = 1'b1;
    cur_req = "R1";
    check("R1", frame_rdata, 0, "frame after reset");
    check("R1", int'(mgmt_done), 0, "done after reset");
    cyc();
    rd_expect("R1", 0, 0, 'h3000);
    rd_expect("R1", 0, 1, 'h7809);
    rd_expect("R1", 0, 4, 'h01E1);
    rd_expect("R1", 0, 29, 0);
    rd_expect("R1", 0, 30, 0);

    cur_req = "R2";
    mgmt(1'b0, 0, 7, 'h1234);
    check("R2", frame_rdata, 'h401E1234, "write frame kept whole");

    cur_req = "R6";
    link_up = 1'b1; cyc();
    rd_expect("R6", 0, 1, 'h782D);
    rd_expect("R8", 0, 29, 'hC0);
    rd_expect("R8", 0, 29, 0);

    cur_req = "R7";
    link_up = 1'b0; cyc();
    rd_expect("R7", 0, 1, 'h7809);
    rd_expect("R7", 0, 29, 'h10);

    cur_req = "R3";
    mgmt(1'b0, 0, 0, 'hFFFF);
    rd_expect("R3", 0, 0, 'h7980);
    rd_expect("R3", 0, 1, 'h7829);
    mgmt(1'b0, 0, 0, 'h1100);
    rd_expect("R3", 0, 0, 'h1100);

    cur_req = "R4";
    mgmt(1'b0, 0, 4, 'hFFFF);
    rd_expect("R4", 0, 4, 'h2DFF);
    mgmt(1'b0, 0, 4, 0);
    rd_expect("R4", 0, 4, 'h0080);

    cur_req = "R5";
    mgmt(1'b0, 0, 30, 'hABCD);
    rd_expect("R5", 0, 30, 'h00CD);

    cur_req = "R9";
    mgmt(1'b0, 0, 5, 'hFFFF);
    mgmt(1'b0, 0, 6, 'hFFFF);
    mgmt(1'b0, 0, 1, 'h0000);
    mgmt(1'b0, 0, 29, 'h00FF);
    rd_expect("R9", 0, 5, 0);
    rd_expect("R9", 0, 6, 0);
    rd_expect("R9", 0, 17, 0);
    rd_expect("R9", 0, 1, 'h7829);
    rd_expect("R9", 0, 29, 0);

    cur_req = "R10";
    mgmt(1'b0, 1, 0, 'h0200);
    mgmt(1'b0, 3, 30, 'h0011);
    rd_expect("R10", 1, 1, 0);
    rd_expect("R10", 0, 0, 'h1100);
    rd_expect("R10", 0, 30, 'h00CD);

    cur_req = "R8";
    link_up = 1'b1;
    rd_expect("R8", 0, 29, 0);
    rd_expect("R8", 0, 29, 'hC0);
    link_up = 1'b0;
    mgmt(1'b0, 0, 0, 'h0200);
    rd_expect("R7", 0, 1, 'h7809);

    cur_req = "R11";
    mgmt(1'b0, 0, 30, 1);
    mgmt(1'b1, 0, 30, 0);
    check("R11", int'(mgmt_done), 1, "back-to-back done");
    cyc();
    check("R11", int'(mgmt_done), 0, "done drops after one cycle");
    cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule